// File: doc/BRIEF.md
# Streaming Gray/Binary Word Converter

This block converts 16-bit words between plain binary and reflected Gray code in a single datapath. The datapath is a chain of shift-and-XOR stages with shift distances 1, 2, 4 and 8. The first stage alone turns a binary word into its Gray code, so its result is brought out as a Gray tap. The full chain computes the running parity from the most significant bit downward, so a Gray word applied at the input comes out at the end as its binary value. Every word presented at the input produces both results, and the consumer reads whichever one matches the meaning of the word it sent.

A per-stage mask parameter decides which stages end in a register. Setting more bits shortens the logic path between flops at the cost of more latency on the binary output. The Gray tap always leaves through a register, because the raw XOR outputs glitch while their source changes. That tap therefore has one cycle of latency whatever the mask. Each output has its own valid flag, which is delayed by the same registers as its data.

The input side carries valid but no ready. The block accepts a word on every clock with no stall and no back-pressure, so a downstream consumer must take every beat its valid flag marks. Words leave in the order they arrived.

Top module: `gray_pipe_conv`

## Requirements
- R1: One cycle after a clock edge that samples `in_valid` high, `gray_data` equals that input word XOR the same word logically shifted right by one with zero fill (for example 0x1234 gives 0x1B2E, 0xFFFF gives 0x8000), for every value of the stage mask.
- R2: The most significant bit of `gray_data` always equals the most significant bit of the input word it came from.
- R3: Each bit i of `bin_data` equals the XOR of input bits i through 15 of the word it came from (for example 0x8000 gives 0xFFFF, 0xAAAA gives 0xCCCC). The latency equals the number of set bits in the stage mask, which is 4 cycles by default.
- R4: `bin_valid` reproduces the `in_valid` pattern, including gaps, delayed by the latency of R3.
- R5: `gray_valid` reproduces the `in_valid` pattern delayed by exactly one cycle.
- R6: While `rst` is high at a clock edge, all pipeline data and valid registers are cleared. At the next sample, both valid outputs and both data outputs read zero. Words that were in flight are dropped.
- R7: For binary inputs that count 0, 1, …, 65535 and then wrap to 0, each Gray output differs from the one before it in exactly one bit.
- R8: When the Gray code of any value k is applied as input, the binary output returns k.
- R9: A new word is accepted on every clock with no stall. Back-to-back words each produce their own output beat, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_data` as a word to convert |
| in_data | input | 16 | Binary word (for the Gray tap) or Gray word (for the binary output) |
| gray_valid | output | 1 | Marks `gray_data` valid |
| gray_data | output | 16 | Gray code of the input word, registered |
| bin_valid | output | 1 | Marks `bin_data` valid |
| bin_data | output | 16 | Binary value recovered from the input word |

## Verification
The bench walks the binary counter through all 65536 values and the wrap back to zero. A stage with sign fill instead of zero fill, or with a wrong shift distance, makes some step change more than one bit, or makes the top bit disagree with the input. A full sweep of Gray codes through the chain exposes a missing or repeated stage, because some value then fails to return to itself. Gapped valid patterns and a reset while words are in flight target misaligned valid delays and registers that survive reset. Such faults show up as beats that are phantom, lost or stale on one output but not on the other.

// File: rtl/gray_pipe_pkg.sv
package gray_pipe_pkg;
  function automatic int count_set(input logic [31:0] mask, input int n);
    int c;
    c = 0;
    for (int i = 0; i < n; i++) c += int'(mask[i]);
    return c;
  endfunction

  function automatic int stage_shift(input int k);
    return 1 << k;
  endfunction
endpackage

// File: rtl/gray_xor_stage.sv
module gray_xor_stage #(
  parameter int W     = 16,
  parameter int SHIFT = 1,
  parameter bit REG   = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         i_valid,
  input  logic [W-1:0] i_data,
  output logic         o_valid,
  output logic [W-1:0] o_data
);
  logic [W-1:0] mixed;
  assign mixed = i_data ^ (i_data >> SHIFT);

  generate
    if (REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          o_data  <= '0;
          o_valid <= 1'b0;
        end else begin
          o_data  <= mixed;
          o_valid <= i_valid;
        end
      end
    end else begin : g_comb
      assign o_data  = mixed;
      assign o_valid = i_valid;
    end
  endgenerate
endmodule

// File: rtl/gray_out_reg.sv
module gray_out_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         i_valid,
  input  logic [W-1:0] i_data,
  output logic         o_valid,
  output logic [W-1:0] o_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      o_data  <= '0;
      o_valid <= 1'b0;
    end else begin
      o_data  <= i_data;
      o_valid <= i_valid;
    end
  end
endmodule

// File: rtl/gray_pipe_conv.sv
module gray_pipe_conv #(
  parameter int                    W    = 16,
  parameter logic [$clog2(W)-1:0]  PIPE = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         gray_valid,
  output logic [W-1:0] gray_data,
  output logic         bin_valid,
  output logic [W-1:0] bin_data
);
  import gray_pipe_pkg::*;

  localparam int NST = $clog2(W);

  logic [NST:0][W-1:0] sd;
  logic [NST:0]        sv;

  assign sd[0] = in_data;
  assign sv[0] = in_valid;

  generate
    for (genvar k = 0; k < NST; k++) begin : g_stage
      gray_xor_stage #(
        .W    (W),
        .SHIFT(stage_shift(k)),
        .REG  (PIPE[k])
      ) u_stage (
        .clk    (clk),
        .rst    (rst),
        .i_valid(sv[k]),
        .i_data (sd[k]),
        .o_valid(sv[k+1]),
        .o_data (sd[k+1])
      );
    end

    if (PIPE[0]) begin : g_tap_shared
      assign gray_data  = sd[1];
      assign gray_valid = sv[1];
    end else begin : g_tap_own
      gray_out_reg #(.W(W)) u_tap (
        .clk    (clk),
        .rst    (rst),
        .i_valid(sv[1]),
        .i_data (sd[1]),
        .o_valid(gray_valid),
        .o_data (gray_data)
      );
    end
  endgenerate

  assign bin_data  = sd[NST];
  assign bin_valid = sv[NST];
endmodule

// File: rtl/gray_pipe_chk.sv
module gray_pipe_chk #(
  parameter int                    W    = 16,
  parameter logic [$clog2(W)-1:0]  PIPE = '1
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] in_data,
  input logic         gray_valid,
  input logic [W-1:0] gray_data,
  input logic         bin_valid,
  input logic [W-1:0] bin_data
);
  import gray_pipe_pkg::*;

  localparam int LAT = count_set(32'(PIPE), $clog2(W));

  logic         exp_v;
  logic [W-1:0] exp_d;

  generate
    if (LAT == 0) begin : g_nolat
      assign exp_v = in_valid;
      assign exp_d = in_data;
    end else begin : g_lat
      logic [LAT-1:0]        dv;
      logic [LAT-1:0][W-1:0] dd;
      always_ff @(posedge clk) begin
        if (rst) begin
          dv <= '0;
          dd <= '0;
        end else begin
          dv[0] <= in_valid;
          dd[0] <= in_data;
          for (int i = 1; i < LAT; i++) begin
            dv[i] <= dv[i-1];
            dd[i] <= dd[i-1];
          end
        end
      end
      assign exp_v = dv[LAT-1];
      assign exp_d = dd[LAT-1];
    end
  endgenerate

  assert_gray_value_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> gray_data == ($past(in_data) ^ ($past(in_data) >> 1)));

  assert_gray_msb_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> gray_data[W-1] == $past(in_data[W-1]));

  assert_bin_inverse_R3: assert property (@(posedge clk) disable iff (rst)
    bin_valid |-> ((bin_data ^ (bin_data >> 1)) == exp_d));

  assert_bin_valid_R4: assert property (@(posedge clk) disable iff (rst)
    bin_valid == exp_v);

  assert_gray_valid_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> gray_valid == $past(in_valid));

  assert_reset_clear_R6: assert property (@(posedge clk)
    rst |=> (!gray_valid && !bin_valid && gray_data == '0 && bin_data == '0));
endmodule

bind gray_pipe_conv gray_pipe_chk #(.W(W), .PIPE(PIPE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .gray_valid(gray_valid),
  .gray_data (gray_data),
  .bin_valid (bin_valid),
  .bin_data  (bin_data)
);

// File: tb/gray_pipe_conv_tb.sv
module gray_pipe_conv_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 16;
  localparam int LAT = 4;
  localparam int NV  = 8;
  // each entry: input, expected Gray, expected binary
  localparam logic [47:0] VEC [NV] = '{
    {16'h0000, 16'h0000, 16'h0000},
    {16'hFFFF, 16'h8000, 16'hAAAA},
    {16'h8000, 16'hC000, 16'hFFFF},
    {16'h0001, 16'h0001, 16'h0001},
    {16'h5555, 16'h7FFF, 16'h6666},
    {16'h1234, 16'h1B2E, 16'h1C27},
    {16'h8001, 16'hC001, 16'hFFFE},
    {16'hAAAA, 16'hFFFF, 16'hCCCC}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         gray_valid, bin_valid;
  logic [W-1:0] gray_data, bin_data;

  int checks = 0;
  int failures = 0;
  int cyc = 8;
  logic         hv [8];
  logic [W-1:0] hg [8];
  logic [W-1:0] hb [8];
  bit           adj_mode = 1'b0;
  bit           have_prev = 1'b0;
  logic [W-1:0] prev_gray = '0;

  gray_pipe_conv u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .gray_valid(gray_valid), .gray_data(gray_data),
    .bin_valid(bin_valid), .bin_data(bin_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] gref(input logic [W-1:0] x);
    logic [W-1:0] g;
    for (int i = 0; i < W; i++) g[i] = x[i] ^ ((i == W-1) ? 1'b0 : x[i+1]);
    return g;
  endfunction

  function automatic logic [W-1:0] bref(input logic [W-1:0] x);
    logic [W-1:0] b;
    for (int i = 0; i < W; i++) begin
      logic p;
      p = 1'b0;
      for (int j = i; j < W; j++) p ^= x[j];
      b[i] = p;
    end
    return b;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 8; i++) hv[i] = 1'b0;
    have_prev = 1'b0;
  endtask

  task automatic check_outputs();
    int gs, bs;
    gs = (cyc - 1) % 8;
    bs = (cyc - LAT) % 8;
    chk(gray_valid == hv[gs], "R5 gray_valid", W'(gray_valid), W'(hv[gs]));
    chk(bin_valid == hv[bs], "R4 bin_valid", W'(bin_valid), W'(hv[bs]));
    if (hv[gs]) begin
      chk(gray_data == hg[gs], "R1 gray_data", gray_data, hg[gs]);
      if (adj_mode && have_prev)
        chk($countones(gray_data ^ prev_gray) == 1, "R7 one-bit step", gray_data, prev_gray);
      prev_gray = gray_data;
      have_prev = 1'b1;
    end
    if (hv[bs]) chk(bin_data == hb[bs], "R3 R8 bin_data", bin_data, hb[bs]);
  endtask

  task automatic step(input logic v, input logic [W-1:0] d, input logic [W-1:0] eg, input logic [W-1:0] eb);
    @(negedge clk);
    check_outputs();
    in_valid = v;
    in_data  = d;
    hv[cyc % 8] = v;
    hg[cyc % 8] = eg;
    hb[cyc % 8] = eb;
    cyc++;
  endtask

  task automatic drain();
    for (int i = 0; i < LAT + 1; i++) step(1'b0, 16'h0, 16'h0, 16'h0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_hist();
    repeat (3) @(negedge clk);
    // R6: reset state
    chk(!gray_valid && !bin_valid, "R6 reset valids", {gray_valid, bin_valid}, 0);
    chk(gray_data == 0 && bin_data == 0, "R6 reset data", gray_data | bin_data, 0);
    rst = 1'b0;

    // Table walk, back to back (R1 R2 R3 R9)
    for (int i = 0; i < NV; i++) step(1'b1, VEC[i][47:32], VEC[i][31:16], VEC[i][15:0]);
    drain();

    // Gapped valid pattern (R4 R5)
    for (int i = 0; i < 12; i++) begin
      logic [W-1:0] d;
      d = W'(i * 16'h1357);
      step((i % 3) != 1, d, gref(d), bref(d));
    end
    drain();

    // R7: binary counter through wrap, Gray steps by one bit
    adj_mode = 1'b1;
    have_prev = 1'b0;
    for (int k = 0; k <= 65536; k++) begin
      logic [W-1:0] d;
      d = W'(k);
      step(1'b1, d, gref(d), bref(d));
    end
    drain();
    adj_mode = 1'b0;

    // R8: every Gray code returns to its binary value
    for (int k = 0; k < 65536; k++) begin
      logic [W-1:0] g;
      g = gref(W'(k));
      step(1'b1, g, gref(g), W'(k));
    end

    // R6: reset while words are in flight
    @(negedge clk);
    check_outputs();
    rst = 1'b1;
    in_valid = 1'b1;
    in_data = 16'h4321;
    @(negedge clk);
    chk(!gray_valid && !bin_valid, "R6 flush valids", {gray_valid, bin_valid}, 0);
    chk(gray_data == 0 && bin_data == 0, "R6 flush data", gray_data | bin_data, 0);
    clear_hist();
    rst = 1'b0;
    in_valid = 1'b0;
    step(1'b1, 16'h8000, 16'hC000, 16'hFFFF);
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule